// File: doc/BRIEF.md
# Multicycle 32-bit RISC Subset Core

This block is a small processor that runs a subset of a simple load/store instruction set with 32 general registers. It works through one memory port. The same port serves instruction fetch and data access. Addresses count bytes, but only whole aligned 32-bit words move across the port. The port is read combinationally: the word at the presented address is valid on `mem_rdata_i` in the same cycle.

Each instruction takes exactly two cycles. In the first cycle the core fetches the word at the program counter and advances the counter by four. In the second cycle it executes the instruction. That execute step covers the register and literal ALU operations, word loads and stores, and the two conditional branches, which also record a return address.

When the core meets an opcode outside the supported set, it raises a sticky flag and stops. Only reset brings it back.

Top module: `mc_risc_core`

## Requirements
- R1: While `rst_ni` is low and right after it rises, the core drives address 0, keeps `mem_we_o` low and keeps `illegal_o` low. Reset clears every register to 0.
- R2: An instruction word holds the opcode in bits [31:26], the destination or data register rc in [25:21], the source register ra in [20:16], the second source rb in [15:11], and the literal in [15:0]. The literal is sign-extended to 32 bits.
- R3: Every instruction takes two cycles. In the fetch cycle the core presents the program counter as the address, with no write. In the execute cycle the counter has already moved on by 4.
- R4: Opcodes `10ffff` compute Reg[rc] = Reg[ra] op Reg[rb]. The function code ffff selects the operation: 0000 add, 0001 subtract, 0010 multiply, 0100 equal, 0101 less-than, 0110 less-or-equal, 1000 and, 1001 or, 1010 xor, 1100 shift left, 1101 logical shift right, 1110 arithmetic shift right.
- R5: Opcodes `11ffff` perform the same operations with the sign-extended literal as the second operand. Opcode 110000 is add-with-literal.
- R6: The compare operations treat both operands as signed and write 1 when the condition holds, 0 otherwise.
- R7: Shifts use only the low 5 bits of the second operand. Multiply keeps the low 32 bits of the product.
- R8: Opcode 011000 (load) writes Mem[Reg[ra]+sxt(lit)] to Reg[rc]. Opcode 011001 (store) writes Reg[rc] to Mem[Reg[ra]+sxt(lit)] with `mem_we_o` high for exactly the execute cycle.
- R9: The two lowest bits of every data address are ignored, so an unaligned address reaches the aligned word that contains it.
- R10: Opcodes 011100 (branch if Reg[ra]==0) and 011101 (branch if Reg[ra]!=0) write PC+4 into Reg[rc]. When the condition holds, they continue at PC+4+4*sxt(lit). Negative offsets form loops.
- R11: Register 31 always reads as 0, and writes to it are discarded.
- R12: Any other opcode sets `illegal_o`. The core then halts: no further memory write and a frozen address. Only reset clears this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | 32 | Byte address, always word aligned |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Word read at `mem_addr_o`, same cycle |
| mem_we_o | output | 1 | Write strobe for stores |
| illegal_o | output | 1 | Unsupported opcode seen, core halted |

## Verification
Branches that are taken backwards repeatedly, with the return address written at the same time, are the hardest to reach from the ports. Only a real program produces them. The stimulus therefore loads short programs into the bench memory: a countdown loop closed by a backward not-equal branch, and forward skips with both branch kinds and both outcomes. Every program ends in a branch to itself. The ALU is swept over every function code and a grid of corner operands. Each operand pair runs in both register and literal form. The results come back through stores and are compared with values the bench computes.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;
  localparam logic [5:0] OP_LD  = 6'b011000;
  localparam logic [5:0] OP_ST  = 6'b011001;
  localparam logic [5:0] OP_BEQ = 6'b011100;
  localparam logic [5:0] OP_BNE = 6'b011101;
  localparam logic [1:0] CLS_REG = 2'b10;
  localparam logic [1:0] CLS_LIT = 2'b11;

  typedef enum logic [3:0] {
    FN_ADD = 4'h0, FN_SUB = 4'h1, FN_MUL = 4'h2,
    FN_CEQ = 4'h4, FN_CLT = 4'h5, FN_CLE = 4'h6,
    FN_AND = 4'h8, FN_OR  = 4'h9, FN_XOR = 4'hA,
    FN_SHL = 4'hC, FN_SHR = 4'hD, FN_SAR = 4'hE
  } alu_fn_e;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_HALT} state_e;

  function automatic logic fn_valid(logic [3:0] f);
    case (f)
      4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6,
      4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mc_decode.sv
module mc_decode
  import mc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RA_W   = 5
) (
  input  logic [31:0]       instr_i,
  output logic [RA_W-1:0]   rc_o,
  output logic [RA_W-1:0]   ra_o,
  output logic [RA_W-1:0]   rb_o,
  output logic [DATA_W-1:0] lit_o,
  output alu_fn_e           fn_o,
  output logic              is_alu_o,
  output logic              use_lit_o,
  output logic              is_ld_o,
  output logic              is_st_o,
  output logic              is_br_o,
  output logic              br_ne_o,
  output logic              illegal_o
);
  logic [5:0] op;
  assign op    = instr_i[31:26];
  assign rc_o  = instr_i[25:21];
  assign ra_o  = instr_i[20:16];
  assign rb_o  = instr_i[15:11];
  assign lit_o = {{(DATA_W-16){instr_i[15]}}, instr_i[15:0]};
  assign fn_o  = alu_fn_e'(op[3:0]);

  always_comb begin
    is_alu_o  = (op[5:4] == CLS_REG || op[5:4] == CLS_LIT) && fn_valid(op[3:0]);
    use_lit_o = op[5:4] == CLS_LIT;
    is_ld_o   = op == OP_LD;
    is_st_o   = op == OP_ST;
    is_br_o   = op == OP_BEQ || op == OP_BNE;
    br_ne_o   = op == OP_BNE;
    illegal_o = !(is_alu_o || is_ld_o || is_st_o || is_br_o);
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_core_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int SH_W = $clog2(DATA_W);
  logic [SH_W-1:0] shamt;
  assign shamt = b_i[SH_W-1:0];

  always_comb begin
    case (fn_i)
      FN_ADD: y_o = a_i + b_i;
      FN_SUB: y_o = a_i - b_i;
      FN_MUL: y_o = a_i * b_i;
      FN_CEQ: y_o = {{(DATA_W-1){1'b0}}, a_i == b_i};
      FN_CLT: y_o = {{(DATA_W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      FN_CLE: y_o = {{(DATA_W-1){1'b0}}, $signed(a_i) <= $signed(b_i)};
      FN_AND: y_o = a_i & b_i;
      FN_OR:  y_o = a_i | b_i;
      FN_XOR: y_o = a_i ^ b_i;
      FN_SHL: y_o = a_i << shamt;
      FN_SHR: y_o = a_i >> shamt;
      FN_SAR: y_o = $unsigned($signed(a_i) >>> shamt);
      default: y_o = '0;
    endcase
  end

  // R6: compares yield 0 or 1 only
  always_comb begin
    if (fn_i == FN_CEQ || fn_i == FN_CLT || fn_i == FN_CLE)
      a_r6_cmp_bool: assert (y_o[DATA_W-1:1] == '0);
  end
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DATA_W = 32,
  parameter int NREG   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(NREG)-1:0] raddr_a_i,
  input  logic [$clog2(NREG)-1:0] raddr_b_i,
  input  logic [$clog2(NREG)-1:0] raddr_c_i,
  output logic [DATA_W-1:0]       rdata_a_o,
  output logic [DATA_W-1:0]       rdata_b_o,
  output logic [DATA_W-1:0]       rdata_c_o,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] waddr_i,
  input  logic [DATA_W-1:0]       wdata_i
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] ZERO_IDX = AW'(NREG - 1);

  logic [DATA_W-1:0] rf_q [NREG-1];

  for (genvar gi = 0; gi < NREG - 1; gi++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rf_q[gi] <= '0;
      else if (we_i && waddr_i == AW'(gi)) rf_q[gi] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i == ZERO_IDX) ? '0 : rf_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == ZERO_IDX) ? '0 : rf_q[raddr_b_i];
  assign rdata_c_o = (raddr_c_i == ZERO_IDX) ? '0 : rf_q[raddr_c_i];

  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != ZERO_IDX) |=> rf_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
  import mc_core_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic              illegal_o
);
  localparam int AW = $clog2(NREG);

  state_e            state_q;
  logic [DATA_W-1:0] pc_q;
  logic [31:0]       ir_q;
  logic              illegal_q;

  logic [AW-1:0]     rc, ra, rb;
  logic [DATA_W-1:0] lit, ra_val, rb_val, rc_val, alu_y, ea, wdata;
  alu_fn_e           fn;
  logic is_alu, use_lit, is_ld, is_st, is_br, br_ne, dec_ill;
  logic exec_ok, br_take, rf_we;

  mc_decode #(.DATA_W(DATA_W), .RA_W(AW)) u_dec (
    .instr_i(ir_q), .rc_o(rc), .ra_o(ra), .rb_o(rb), .lit_o(lit), .fn_o(fn),
    .is_alu_o(is_alu), .use_lit_o(use_lit), .is_ld_o(is_ld), .is_st_o(is_st),
    .is_br_o(is_br), .br_ne_o(br_ne), .illegal_o(dec_ill)
  );

  mc_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .raddr_a_i(ra), .raddr_b_i(rb), .raddr_c_i(rc),
    .rdata_a_o(ra_val), .rdata_b_o(rb_val), .rdata_c_o(rc_val),
    .we_i(rf_we), .waddr_i(rc), .wdata_i(wdata)
  );

  mc_alu #(.DATA_W(DATA_W)) u_alu (
    .fn_i(fn), .a_i(ra_val), .b_i(use_lit ? lit : rb_val), .y_o(alu_y)
  );

  assign exec_ok = state_q == S_EXEC && !dec_ill;
  assign ea      = ra_val + lit;
  assign br_take = br_ne ? (ra_val != '0) : (ra_val == '0);
  assign rf_we   = exec_ok && (is_alu || is_ld || is_br);

  always_comb begin
    if (is_ld)      wdata = mem_rdata_i;
    else if (is_br) wdata = pc_q;
    else            wdata = alu_y;
  end

  always_comb begin
    if (exec_ok && (is_ld || is_st)) mem_addr_o = {ea[DATA_W-1:2], 2'b00};
    else                             mem_addr_o = {pc_q[DATA_W-1:2], 2'b00};
  end
  assign mem_we_o    = exec_ok && is_st;
  assign mem_wdata_o = rc_val;
  assign illegal_o   = illegal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_FETCH;
      pc_q      <= '0;
      ir_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      case (state_q)
        S_FETCH: begin
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_q + DATA_W'(4);
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (dec_ill) begin
            illegal_q <= 1'b1;
            state_q   <= S_HALT;
          end else begin
            if (is_br && br_take) pc_q <= pc_q + (lit << 2);
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  a_r3_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_EXEC |-> pc_q == $past(pc_q) + DATA_W'(4));
  a_r3_fetch_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_FETCH |-> !mem_we_o);
  a_r8_we_after_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(state_q) == S_FETCH);
  a_r12_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o && !mem_we_o && $stable(mem_addr_o));
endmodule

// File: tb/mc_risc_core_tb.sv
module mc_risc_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] LD = 6'b011000, ST = 6'b011001, BEQ = 6'b011100, BNE = 6'b011101;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, illegal;
  logic [31:0] mem [64];
  logic ld_we = 1'b0;
  logic [5:0] ld_idx = '0;
  logic [31:0] ld_dat = '0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_risc_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_we_o(mem_we), .illegal_o(illegal)
  );

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) begin
    if (ld_we) mem[ld_idx] <= ld_dat;
    else if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
  end

  function automatic logic [31:0] enc_r(logic [5:0] op, int rc, int ra, int rb);
    return {op, 5'(rc), 5'(ra), 5'(rb), 11'b0};
  endfunction
  function automatic logic [31:0] enc_l(logic [5:0] op, int rc, int ra, logic [15:0] lit);
    return {op, 5'(rc), 5'(ra), lit};
  endfunction

  function automatic logic [31:0] ref_alu(logic [3:0] f, logic [31:0] a, logic [31:0] b);
    case (f)
      4'h0: return a + b;
      4'h1: return a - b;
      4'h2: return a * b;
      4'h4: return {31'b0, a == b};
      4'h5: return {31'b0, $signed(a) < $signed(b)};
      4'h6: return {31'b0, $signed(a) <= $signed(b)};
      4'h8: return a & b;
      4'h9: return a | b;
      4'hA: return a ^ b;
      4'hC: return a << b[4:0];
      4'hD: return a >> b[4:0];
      default: return $unsigned($signed(a) >>> b[4:0]);
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(int idx, logic [31:0] val);
    @(negedge clk);
    ld_we = 1'b1; ld_idx = 6'(idx); ld_dat = val;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_ni = 1'b0;
  endtask

  task automatic release_run(int n);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_0023, 32'h0000_FFFD};
  logic [3:0]  fns  [12] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hC, 4'hD, 4'hE};

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 addr", mem_addr, 32'h0);
    check("R1 we", {31'b0, mem_we}, 32'h0);
    check("R1 illegal", {31'b0, illegal}, 32'h0);

    // R2 R4 R5 R6 R7: ALU sweep in register and literal form
    for (int fi = 0; fi < 12; fi++) begin
      for (int ai = 0; ai < 6; ai++) begin
        for (int bi = 0; bi < 6; bi++) begin
          logic [31:0] a, b, bl;
          string tag;
          a = vals[ai]; b = vals[bi];
          bl = {{16{b[15]}}, b[15:0]};
          tag = (fns[fi] inside {4'h4, 4'h5, 4'h6}) ? "R2 R4 R6" :
                (fns[fi] inside {4'h2, 4'hC, 4'hD, 4'hE}) ? "R2 R4 R7" : "R2 R4";
          hold_reset();
          poke(0, enc_l(LD, 1, 31, 16'd128));
          poke(1, enc_l(LD, 2, 31, 16'd132));
          poke(2, enc_r({2'b10, fns[fi]}, 3, 1, 2));
          poke(3, enc_l({2'b11, fns[fi]}, 4, 1, b[15:0]));
          poke(4, enc_l(ST, 3, 31, 16'd136));
          poke(5, enc_l(ST, 4, 31, 16'd140));
          poke(6, enc_l(BEQ, 31, 31, 16'hFFFF));
          poke(32, a); poke(33, b); poke(34, SENT); poke(35, SENT);
          release_run(16);
          check(tag, mem[34], ref_alu(fns[fi], a, b));
          check("R5 literal form", mem[35], ref_alu(fns[fi], a, bl));
        end
      end
    end

    // R10: forward branches, both kinds, both outcomes
    for (int k = 0; k < 4; k++) begin
      logic ne, taken;
      logic [15:0] v;
      ne = k[1];
      v = k[0] ? 16'd5 : 16'd0;
      taken = ne ? (v != 0) : (v == 0);
      hold_reset();
      poke(0, enc_l(6'b110000, 1, 31, v));
      poke(1, enc_l(ne ? BNE : BEQ, 5, 1, 16'd1));
      poke(2, enc_l(6'b110000, 6, 31, 16'd99));
      poke(3, enc_l(ST, 5, 31, 16'd136));
      poke(4, enc_l(ST, 6, 31, 16'd140));
      poke(5, enc_l(BEQ, 31, 31, 16'hFFFF));
      poke(34, SENT); poke(35, SENT);
      release_run(20);
      check("R10 return address", mem[34], 32'd8);
      check("R10 branch outcome", mem[35], taken ? 32'd0 : 32'd99);
    end

    // R3 R10 R11: countdown loop with backward branch, then write to r31
    hold_reset();
    poke(0, enc_l(6'b110000, 1, 31, 16'd4));
    poke(1, enc_r(6'b100000, 2, 2, 1));
    poke(2, enc_l(6'b110001, 1, 1, 16'd1));
    poke(3, enc_l(BNE, 31, 1, 16'hFFFD));
    poke(4, enc_l(ST, 2, 31, 16'd136));
    poke(5, enc_l(6'b110000, 31, 31, 16'd7));
    poke(6, enc_l(ST, 31, 31, 16'd140));
    poke(7, enc_l(BEQ, 31, 31, 16'hFFFF));
    poke(34, SENT); poke(35, SENT);
    @(negedge clk);
    rst_ni = 1'b1;
    check("R3 fetch addr", mem_addr, 32'd0);
    @(negedge clk);
    check("R3 exec pc", mem_addr, 32'd4);
    check("R3 no write", {31'b0, mem_we}, 32'h0);
    @(negedge clk);
    check("R3 next fetch", mem_addr, 32'd4);
    repeat (60) @(negedge clk);
    check("R10 loop sum", mem[34], 32'd10);
    check("R11 r31 write discarded", mem[35], 32'd0);

    // R9 R1: unaligned addresses, register cleared by reset
    hold_reset();
    poke(0, enc_l(LD, 1, 31, 16'd131));
    poke(1, enc_l(ST, 1, 31, 16'd137));
    poke(2, enc_l(ST, 1, 31, 16'd143));
    poke(3, enc_l(ST, 3, 31, 16'd132));
    poke(4, enc_l(BEQ, 31, 31, 16'hFFFF));
    poke(32, 32'hCAFE_F00D); poke(33, SENT); poke(34, SENT); poke(35, SENT);
    release_run(14);
    check("R9 load and store 137", mem[34], 32'hCAFE_F00D);
    check("R8 R9 store 143", mem[35], 32'hCAFE_F00D);
    check("R1 register reset", mem[33], 32'd0);

    // R12: illegal opcode halts
    hold_reset();
    poke(0, enc_l(6'b110000, 1, 31, 16'd5));
    poke(1, enc_l(ST, 1, 31, 16'd136));
    poke(2, 32'h0000_0000);
    poke(3, enc_l(ST, 1, 31, 16'd140));
    poke(34, SENT); poke(35, SENT);
    release_run(20);
    check("R12 illegal flag", {31'b0, illegal}, 32'h1);
    check("R12 store before", mem[34], 32'd5);
    check("R12 no store after", mem[35], SENT);
    check("R12 frozen addr", mem_addr, 32'd12);
    check("R12 no write", {31'b0, mem_we}, 32'h0);
    hold_reset();
    @(negedge clk);
    check("R1 reset clears illegal", {31'b0, illegal}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule